// File: doc/BRIEF.md
# Triggered Pattern Playback Controller

This block sequences the playback of a stored digital pattern onto a 32-bit output bus, one word per sample clock. Software loads a word count, a pass count and a mode, then arms the controller. The controller waits for a start condition. When it sees one, it walks a read address through the pattern memory and registers each returned word onto the output bus. It does this once, for a programmed number of passes, or without end.

The start condition is an edge on a trigger input, with a selectable polarity, or a software strobe. The start can also be switched off, in which case playback begins as soon as the controller is armed. A level-sensitive pause input, with its own polarity and its own off switch, freezes the address and holds the output word while it is active. Two status outputs report the controller's phase: one while it waits for a start, and one while fresh pattern data is on the bus. A one-cycle pulse marks the final word of a finite run. An abort input returns the controller to idle from any state and turns all drivers off.

The pattern memory is outside the block and has an asynchronous read port: `memData` must hold the word at `memAddr` within the same cycle.

Top module: `pattern_playback_ctrl`

## Requirements
- R1: After reset, `dataOe` and `dataOut` are all zero, `memAddr` is zero, and `readyForStart`, `dataActive` and `donePulse` are low.
- R2: In idle, an `armReq` with an accepted configuration latches the length, repeat count and mode, and moves to armed on the next edge. `readyForStart` is high for exactly as long as the controller is armed.
- R3: An `armReq` is rejected, and the controller stays idle, when `cfgLength` is zero or when `cfgMode` is 1 (counted) with `cfgRepeat` zero.
- R4: While armed, a start edge begins playback. With `cfgStartFall`=0 the edge is a 0→1 change of `startTrig` between two sampled cycles; with `cfgStartFall`=1 it is a 1→0 change. An edge of the other polarity does nothing.
- R5: While armed, `cfgStartOff`=1 or a `swStart` pulse begins playback on the next edge without any trigger edge.
- R6: Each playback cycle outputs `memAddr` to the memory, registers `memData` onto `dataOut` and `chanDir` onto `dataOe`, and steps the address from 0 up to length−1, then wraps back to 0.
- R7: The pause is active when `cfgPauseOff`=0 and `pauseTrig` differs from `cfgPauseLow`. While the pause is active, the address does not advance, `dataOut` holds its value and `dataActive` is low the cycle after.
- R8: In mode 0 (once), exactly length words are played before the run ends.
- R9: In mode 1 (counted), exactly length×`cfgRepeat` words are played before the run ends.
- R10: In modes 2 and 3 (loop), playback wraps without end and no `donePulse` occurs.
- R11: `donePulse` is high for exactly one cycle, and that cycle is the one in which the last word of a finite run appears on `dataOut`. The controller is idle on the next cycle.
- R12: `abortReq` sends the controller to idle from any state on the next edge, clears `dataOe` and drops `dataActive`.
- R13: Start edges, software starts and `armReq` arriving while playback is running or paused have no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Asynchronous active-low reset |
| armReq | input | 1 | Arm pulse, honoured only in idle |
| abortReq | input | 1 | Return to idle and turn drivers off |
| cfgMode | input | 2 | 0 once, 1 counted, 2 or 3 loop |
| cfgLength | input | ADDR_W+1 | Pattern length in words |
| cfgRepeat | input | REP_W | Pass count for counted mode |
| cfgStartOff | input | 1 | Start without waiting for a trigger |
| cfgStartFall | input | 1 | Start edge polarity: 0 rising, 1 falling |
| cfgPauseOff | input | 1 | Ignore the pause input |
| cfgPauseLow | input | 1 | Pause active level: 0 high, 1 low |
| chanDir | input | DATA_W | Per-channel drive enable applied during playback |
| startTrig | input | 1 | Start trigger input |
| pauseTrig | input | 1 | Pause trigger input |
| swStart | input | 1 | Software start strobe |
| memAddr | output | ADDR_W | Pattern memory read address |
| memRdEn | output | 1 | High on cycles that consume a memory word |
| memData | input | DATA_W | Word read at memAddr |
| dataOut | output | DATA_W | Registered output pattern word |
| dataOe | output | DATA_W | Registered per-channel output enable |
| readyForStart | output | 1 | Armed and waiting for a start |
| dataActive | output | 1 | A fresh pattern word is on dataOut |
| donePulse | output | 1 | Last word of a finite run is on dataOut |

## Verification
The bench tests a trigger edge of the wrong polarity while the controller is armed. A design that decodes the polarity wrongly starts early, and a design that only watches for levels starts at once. The bench pauses in the middle of a pass and checks that the output word stays put. A design that advances during the pause would skip words, and one that misses the resume would stall. It counts the words played in once and counted modes, since an off-by-one in the wrap or pass comparison plays one pass too many or ends a word early. It also fires start edges and arm requests during playback, arms with a zero length and with a zero pass count, and aborts from the armed and loop states. A design that re-arms, accepts bad settings or leaves drivers on would show up in those checks.

// File: rtl/pbk_pkg.sv
package pbk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ARMED = 3'd1,
    ST_RUN   = 3'd2,
    ST_PAUSE = 3'd3,
    ST_DONE  = 3'd4
  } pbk_state_e;

  typedef enum logic [1:0] {
    PM_ONCE  = 2'd0,
    PM_COUNT = 2'd1,
    PM_LOOP  = 2'd2,
    PM_LOOP2 = 2'd3
  } pbk_mode_e;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic load;     // capture length and repeat count
    logic restart;  // address and pass counter to zero
    logic advance;  // consume one word
    logic clear;    // drivers off
  } pbk_strobe_t;

endpackage

// File: rtl/pbk_ctrl.sv
module pbk_ctrl
  import pbk_pkg::*;
#(
  parameter int LEN_W = 11,
  parameter int REP_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             armReq,
  input  logic             abortReq,
  input  logic [1:0]       cfgMode,
  input  logic [LEN_W-1:0] cfgLength,
  input  logic [REP_W-1:0] cfgRepeat,
  input  logic             startOff,
  input  logic             startFall,
  input  logic             swStart,
  input  logic             startTrig,
  input  logic             pauseOff,
  input  logic             pauseLow,
  input  logic             pauseTrig,
  input  logic             atEnd,
  input  logic             finalPass,
  output pbk_strobe_t      strobe,
  output logic             readyForStart,
  output logic             donePulse
);

  pbk_state_e state, stateNext;
  pbk_mode_e  modeQ;
  logic       startPrev;
  logic       startEdge, startGo, pauseAct, cfgValid, lastWord;

  always_comb begin
    startEdge = startFall ? (startPrev & ~startTrig) : (~startPrev & startTrig);
    startGo   = startOff | swStart | startEdge;
    pauseAct  = ~pauseOff & (pauseTrig ^ pauseLow);
    cfgValid  = (cfgLength != '0) &&
                !((pbk_mode_e'(cfgMode) == PM_COUNT) && (cfgRepeat == '0));
    lastWord  = atEnd && ((modeQ == PM_ONCE) || ((modeQ == PM_COUNT) && finalPass));
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    if (abortReq) begin
      stateNext    = ST_IDLE;
      strobe.clear = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (armReq && cfgValid) begin
            stateNext   = ST_ARMED;
            strobe.load = 1'b1;
          end
        end
        ST_ARMED: begin
          if (startGo) begin
            stateNext      = ST_RUN;
            strobe.restart = 1'b1;
          end
        end
        ST_RUN, ST_PAUSE: begin
          if (pauseAct) begin
            stateNext = ST_PAUSE;
          end else begin
            strobe.advance = 1'b1;
            stateNext      = lastWord ? ST_DONE : ST_RUN;
          end
        end
        ST_DONE: stateNext = ST_IDLE;
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      modeQ     <= PM_ONCE;
      startPrev <= 1'b0;
    end else begin
      state     <= stateNext;
      startPrev <= startTrig;
      if (strobe.load) modeQ <= pbk_mode_e'(cfgMode);
    end
  end

  assign readyForStart = (state == ST_ARMED);
  assign donePulse     = (state == ST_DONE);

  // R11: completion marker lasts a single cycle
  p_done_single_r11: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

  // R12: abort lands in idle
  p_abort_idle_r12: assert property (@(posedge clk) disable iff (!rstN)
    abortReq |=> (state == ST_IDLE));

  // R3: a zero length never leaves idle
  p_reject_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && armReq && !abortReq && cfgLength == '0) |=> (state == ST_IDLE));

  // R13: playback cannot fall back to armed or idle except by abort or completion
  p_no_rearm_r13: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_RUN || state == ST_PAUSE) && !abortReq)
      |=> (state == ST_RUN || state == ST_PAUSE || state == ST_DONE));

endmodule

// File: rtl/pbk_datapath.sv
module pbk_datapath
  import pbk_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 10,
  parameter int REP_W  = 16,
  localparam int LEN_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  pbk_strobe_t       strobe,
  input  logic [LEN_W-1:0]  cfgLength,
  input  logic [REP_W-1:0]  cfgRepeat,
  input  logic [DATA_W-1:0] memData,
  input  logic [DATA_W-1:0] chanDir,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] dataOut,
  output logic [DATA_W-1:0] dataOe,
  output logic              dataActive,
  output logic              atEnd,
  output logic              finalPass
);

  logic [ADDR_W-1:0] addrQ;
  logic [LEN_W-1:0]  lenQ;
  logic [REP_W-1:0]  repQ, passQ;
  logic [DATA_W-1:0] dataQ;
  logic              activeQ;

  assign atEnd     = ({1'b0, addrQ} == (lenQ - LEN_W'(1)));
  assign finalPass = (passQ == (repQ - REP_W'(1)));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenQ <= '0;
      repQ <= '0;
    end else if (strobe.load) begin
      lenQ <= cfgLength;
      repQ <= cfgRepeat;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      passQ <= '0;
    end else if (strobe.restart) begin
      addrQ <= '0;
      passQ <= '0;
    end else if (strobe.advance) begin
      if (atEnd) begin
        addrQ <= '0;
        passQ <= passQ + REP_W'(1);
      end else begin
        addrQ <= addrQ + ADDR_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ   <= '0;
      activeQ <= 1'b0;
    end else begin
      activeQ <= strobe.advance & ~strobe.clear;
      if (strobe.advance) dataQ <= memData;
    end
  end

  // one enable flop per channel
  for (genvar i = 0; i < DATA_W; i++) begin : g_oe
    logic oeBit;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               oeBit <= 1'b0;
      else if (strobe.clear)   oeBit <= 1'b0;
      else if (strobe.advance) oeBit <= chanDir[i];
    end
    assign dataOe[i] = oeBit;
  end

  assign memAddr    = addrQ;
  assign dataOut    = dataQ;
  assign dataActive = activeQ;

  // R7: the word on the bus only changes on a consumed cycle
  p_hold_on_pause_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.advance |=> $stable(dataOut));

  // R6: the read address stays inside the loaded pattern
  p_addr_in_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |-> ({1'b0, addrQ} < lenQ));

  // R12: drivers are off after a clear
  p_abort_clears_r12: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (dataOe == '0 && !dataActive));

endmodule

// File: rtl/pattern_playback_ctrl.sv
module pattern_playback_ctrl
  import pbk_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 10,
  parameter int REP_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              armReq,
  input  logic              abortReq,
  input  logic [1:0]        cfgMode,
  input  logic [ADDR_W:0]   cfgLength,
  input  logic [REP_W-1:0]  cfgRepeat,
  input  logic              cfgStartOff,
  input  logic              cfgStartFall,
  input  logic              cfgPauseOff,
  input  logic              cfgPauseLow,
  input  logic [DATA_W-1:0] chanDir,
  input  logic              startTrig,
  input  logic              pauseTrig,
  input  logic              swStart,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRdEn,
  input  logic [DATA_W-1:0] memData,
  output logic [DATA_W-1:0] dataOut,
  output logic [DATA_W-1:0] dataOe,
  output logic              readyForStart,
  output logic              dataActive,
  output logic              donePulse
);

  localparam int LEN_W = ADDR_W + 1;

  pbk_strobe_t strobe;
  logic        atEnd, finalPass;

  pbk_ctrl #(.LEN_W(LEN_W), .REP_W(REP_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .armReq       (armReq),
    .abortReq     (abortReq),
    .cfgMode      (cfgMode),
    .cfgLength    (cfgLength),
    .cfgRepeat    (cfgRepeat),
    .startOff     (cfgStartOff),
    .startFall    (cfgStartFall),
    .swStart      (swStart),
    .startTrig    (startTrig),
    .pauseOff     (cfgPauseOff),
    .pauseLow     (cfgPauseLow),
    .pauseTrig    (pauseTrig),
    .atEnd        (atEnd),
    .finalPass    (finalPass),
    .strobe       (strobe),
    .readyForStart(readyForStart),
    .donePulse    (donePulse)
  );

  pbk_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .REP_W(REP_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cfgLength (cfgLength),
    .cfgRepeat (cfgRepeat),
    .memData   (memData),
    .chanDir   (chanDir),
    .memAddr   (memAddr),
    .dataOut   (dataOut),
    .dataOe    (dataOe),
    .dataActive(dataActive),
    .atEnd     (atEnd),
    .finalPass (finalPass)
  );

  assign memRdEn = strobe.advance;

endmodule

// File: tb/pattern_playback_ctrl_test.sv
`timescale 1ns/1ps
module pattern_playback_ctrl_test;

  localparam int DW = 32;
  localparam int AW = 10;
  localparam int RW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic armReq = 0, abortReq = 0, cfgStartOff = 0, cfgStartFall = 0;
  logic cfgPauseOff = 0, cfgPauseLow = 0, startTrig = 0, pauseTrig = 0, swStart = 0;
  logic [1:0] cfgMode = 0;
  logic [AW:0] cfgLength = 0;
  logic [RW-1:0] cfgRepeat = 0;
  logic [DW-1:0] chanDir = 0;
  logic [AW-1:0] memAddr;
  logic memRdEn;
  logic [DW-1:0] memData, dataOut, dataOe;
  logic readyForStart, dataActive, donePulse;

  int checks = 0, errors = 0, cycles = 0;
  int activeCnt = 0, doneCnt = 0;

  always #5 clk = ~clk;

  function automatic logic [DW-1:0] pat(input int a);
    logic [DW-1:0] v;
    v = DW'(a) * 32'h9E3779B1;
    return v ^ 32'hC3A50F0F;
  endfunction

  assign memData = pat(int'(memAddr));

  pattern_playback_ctrl #(.DATA_W(DW), .ADDR_W(AW), .REP_W(RW)) uut (
    .clk(clk), .rstN(rstN), .armReq(armReq), .abortReq(abortReq),
    .cfgMode(cfgMode), .cfgLength(cfgLength), .cfgRepeat(cfgRepeat),
    .cfgStartOff(cfgStartOff), .cfgStartFall(cfgStartFall),
    .cfgPauseOff(cfgPauseOff), .cfgPauseLow(cfgPauseLow), .chanDir(chanDir),
    .startTrig(startTrig), .pauseTrig(pauseTrig), .swStart(swStart),
    .memAddr(memAddr), .memRdEn(memRdEn), .memData(memData),
    .dataOut(dataOut), .dataOe(dataOe), .readyForStart(readyForStart),
    .dataActive(dataActive), .donePulse(donePulse)
  );

  // behavioural reference: 0 idle, 1 armed, 2 playing, 3 held, 4 finished
  int mState = 0, mAddr = 0, mPass = 0, mLen = 0, mRep = 0, mMode = 0;
  logic [DW-1:0] mData = 0, mOe = 0;
  bit mActive = 0, mDone = 0, mPrev = 0;

  always @(posedge clk) begin
    bit edgeSeen, held, fin;
    if (!rstN) begin
      mState = 0; mAddr = 0; mPass = 0; mData = 0; mOe = 0;
      mActive = 0; mDone = 0; mPrev = 0;
    end else begin
      edgeSeen = cfgStartFall ? (mPrev && !startTrig) : (!mPrev && startTrig);
      held = !cfgPauseOff && (pauseTrig != cfgPauseLow);
      mActive = 0; mDone = 0;
      if (abortReq) begin
        mState = 0; mOe = 0;
      end else if (mState == 0) begin
        if (armReq && cfgLength != 0 && !(cfgMode == 1 && cfgRepeat == 0)) begin
          mLen = int'(cfgLength); mRep = int'(cfgRepeat); mMode = int'(cfgMode);
          mState = 1;
        end
      end else if (mState == 1) begin
        if (cfgStartOff || swStart || edgeSeen) begin
          mState = 2; mAddr = 0; mPass = 0;
        end
      end else if (mState == 2 || mState == 3) begin
        if (held) mState = 3;
        else begin
          mData = pat(mAddr); mOe = chanDir; mActive = 1; mState = 2;
          if (mAddr == mLen - 1) begin
            mAddr = 0;
            fin = (mMode == 0) || (mMode == 1 && mPass == mRep - 1);
            if (fin) begin mState = 4; mDone = 1; end
            else mPass = mPass + 1;
          end else mAddr = mAddr + 1;
        end
      end else mState = 0;
      mPrev = startTrig;
    end
  end

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    chk("R6 dataOut", dataOut, mData);
    chk("R6 dataOe", dataOe, mOe);
    chk("R6 memAddr", DW'(memAddr), DW'(mAddr));
    chk("R2 readyForStart", DW'(readyForStart), DW'(mState == 1));
    chk("R7 dataActive", DW'(dataActive), DW'(mActive));
    chk("R11 donePulse", DW'(donePulse), DW'(mDone));
    if (dataActive) activeCnt++;
    if (donePulse) doneCnt++;
  endtask

  task automatic runToDone(input int limit);
    for (int i = 0; i < limit; i++) begin
      step();
      if (donePulse) break;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: run hung actual=%0d expected<=20000 cycles", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] heldWord;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    chk("R1 dataOe reset", dataOe, '0);
    chk("R1 dataOut reset", dataOut, '0);
    chk("R1 memAddr reset", DW'(memAddr), '0);
    chk("R1 ready reset", DW'(readyForStart), 0);
    chk("R1 active reset", DW'(dataActive), 0);

    // once mode, rising start
    cfgMode = 0; cfgLength = 5; chanDir = 32'hFFFF_0000;
    armReq = 1; step(); armReq = 0;
    chk("R2 armed", DW'(readyForStart), 1);
    step(); step();
    chk("R2 still waiting", DW'(readyForStart), 1);
    startTrig = 1; step();
    activeCnt = 0; doneCnt = 0;
    runToDone(50);
    chk("R8 once word count", activeCnt, 5);
    chk("R11 done once", doneCnt, 1);
    startTrig = 0; step();
    chk("R11 idle after done", DW'(readyForStart), 0);

    // counted mode, falling start, pause and stray triggers
    cfgMode = 1; cfgRepeat = 3; cfgLength = 4; cfgStartFall = 1; chanDir = 32'h0F0F_A5A5;
    step();
    armReq = 1; step(); armReq = 0;
    startTrig = 1; step(); step();
    chk("R4 wrong polarity ignored", DW'(readyForStart), 1);
    startTrig = 0; step();
    activeCnt = 0; doneCnt = 0;
    step(); step(); step();
    pauseTrig = 1; step();
    heldWord = dataOut;
    for (int i = 0; i < 4; i++) begin
      step();
      chk("R7 word held", dataOut, heldWord);
      chk("R7 inactive while held", DW'(dataActive), 0);
    end
    pauseTrig = 0;
    startTrig = 1; swStart = 1; step();
    startTrig = 0; swStart = 0; armReq = 1; step(); armReq = 0;
    chk("R13 no rearm", DW'(readyForStart), 0);
    runToDone(100);
    chk("R9 counted word count", activeCnt, 12);
    chk("R11 done counted", doneCnt, 1);
    step();

    // rejected configurations
    cfgLength = 0; cfgMode = 0; armReq = 1; step(); armReq = 0;
    chk("R3 zero length", DW'(readyForStart), 0);
    cfgLength = 4; cfgMode = 1; cfgRepeat = 0; armReq = 1; step(); armReq = 0;
    chk("R3 zero repeat", DW'(readyForStart), 0);
    step();

    // loop mode, start off, low-active pause
    cfgStartFall = 0; cfgMode = 2; cfgLength = 3; cfgStartOff = 1;
    cfgPauseLow = 1; pauseTrig = 1; chanDir = 32'h1234_8765;
    armReq = 1; step(); armReq = 0;
    step();
    activeCnt = 0; doneCnt = 0;
    step();
    chk("R5 start off plays", DW'(dataActive), 1);
    for (int i = 0; i < 19; i++) step();
    chk("R10 loop words", activeCnt, 20);
    chk("R10 no done", doneCnt, 0);
    pauseTrig = 0; step(); step();
    chk("R7 low-active pause", DW'(dataActive), 0);
    pauseTrig = 1; step();
    abortReq = 1; step(); abortReq = 0;
    chk("R12 oe cleared", dataOe, '0);
    chk("R12 inactive", DW'(dataActive), 0);
    chk("R12 not armed", DW'(readyForStart), 0);
    cfgStartOff = 0; cfgPauseLow = 0; pauseTrig = 0;

    // software start
    cfgMode = 0; cfgLength = 2;
    armReq = 1; step(); armReq = 0;
    step();
    chk("R5 waits without strobe", DW'(readyForStart), 1);
    swStart = 1; step(); swStart = 0;
    activeCnt = 0; doneCnt = 0;
    runToDone(20);
    chk("R5 software start words", activeCnt, 2);
    step();

    // abort while armed
    armReq = 1; step(); armReq = 0;
    abortReq = 1; step(); abortReq = 0;
    chk("R12 abort from armed", DW'(readyForStart), 0);
    startTrig = 1; step(); step();
    chk("R12 idle ignores start", DW'(dataActive), 0);
    startTrig = 0; step();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule